// File: doc/BRIEF.md
# Programmable Period Timer with Sleep Release

This block is a free-running 16-bit counter that advances by one on every clock and folds back to zero at a programmable boundary. Software sets the boundary and the current count through a small port-style interface: one port address holds the period, another holds the counter, and both can be written and read back. A period of zero makes the counter use its full 16-bit range.

The timer also paces a processor sleep. While the processor raises its sleep request, the block holds it stalled and releases it with a one-cycle wake pulse in the cycle where the counter folds back to zero. A program that sleeps once per period therefore runs in step with the timer, whatever work it did before sleeping.

Changing the period leaves the counter alone. If the new period is at or below the current count, the counter runs on to the top of its range, wraps to zero, and counts modulo the new period from then on.

Top module: `ptim_top`

## Requirements
- R1: After reset both the period and the counter read back as 0, and `wake_o` is low.
- R2: With no counter write and the count not at its fold point, the counter increases by exactly 1 each clock.
- R3: With a nonzero period P, a count of P-1 is followed by 0; with period 0 the counter runs modulo 65536 (0xFFFF is followed by 0).
- R4: Port address 8 writes and reads the period, address 9 the counter; a write to any other address changes neither, and reading any other address returns 0. Reads are combinational.
- R5: A period write does not change the counter; when the period is at or below the count, the counter continues to 0xFFFF, wraps to 0, then counts modulo the new period.
- R6: A counter write takes priority over the increment and the fold: the next count is the written value, and no wake is given in that cycle.
- R7: `wake_o` is high for one cycle only, in a cycle where the count folds to zero and the sleep request was already high in the previous cycle and still is.
- R8: A sleep request that first rises in a fold cycle is not woken by that fold; it is released at the next fold.
- R9: `hold_o` is high whenever the sleep request is high and `wake_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the port interface |
| wr_addr | input | 4 | Port address of the write |
| wr_data | input | 16 | Data written |
| rd_addr | input | 4 | Port address of the read |
| rd_data | output | 16 | Read data for `rd_addr` |
| sleep_req | input | 1 | Processor asks to sleep until the next fold |
| wake_o | output | 1 | One-cycle release pulse |
| hold_o | output | 1 | Processor must stay stalled |

## Verification
The assertions assume the sleep requester behaves like a stalled processor: it keeps its request up until released and may drop it afterwards, and it does not issue counter writes it expects to produce a fold. They also take the write address and data as stable within a cycle and the reset as synchronous. The bench drives every input at the falling edge, holds the sleep request steady across each waiting window, and places counter writes either well away from a fold or exactly on one to exercise the priority rule.

// File: rtl/ptim_pkg.sv
// Package for the period timer: read-source selection shared by decoder and top.
// Assumes nothing beyond the enum being decoded in one place.
package ptim_pkg;
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PRD  = 2'd1,
        RSEL_CNT  = 2'd2
    } ptim_rsel_e;
endpackage

// File: rtl/ptim_decode.sv
// Address decoder for the timer port interface.
// Produces write enables for the period and counter registers and a read select.
// Assumes the two addresses differ and fit in ADDR_W bits.
module ptim_decode
    import ptim_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PRD_ADDR = 8,
    parameter int CNT_ADDR = 9
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prd_we,
    output logic              cnt_we,
    output ptim_rsel_e        rd_sel
);
    localparam logic [ADDR_W-1:0] PrdA = ADDR_W'(PRD_ADDR);
    localparam logic [ADDR_W-1:0] CntA = ADDR_W'(CNT_ADDR);

    // Write strobes per register.
    always_comb begin
        prd_we = wr_en && (wr_addr == PrdA);
        cnt_we = wr_en && (wr_addr == CntA);
    end

    // Read source selection; unmapped addresses read as nothing.
    always_comb begin
        if (rd_addr == PrdA)      rd_sel = RSEL_PRD;
        else if (rd_addr == CntA) rd_sel = RSEL_CNT;
        else                      rd_sel = RSEL_NONE;
    end
endmodule

// File: rtl/ptim_counter.sv
// Modulo counter: steps by one each clock, folds to zero at period-1, or at the
// top of its range (covers period 0 and a period programmed below the count).
// A counter write wins over stepping and suppresses the fold indication.
module ptim_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prd_q,
    input  logic         cnt_we,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic         roll
);
    localparam logic [W-1:0] TopVal = {W{1'b1}};

    logic [W-1:0] last_val;
    logic         at_end;

    // Fold point: period-1 wraps to all-ones for period 0, giving full range.
    always_comb begin
        last_val = prd_q - W'(1);
        at_end   = (cnt_q == last_val) || (cnt_q == TopVal);
        roll     = at_end && !cnt_we;
    end

    // Counter state update with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= wr_data;
        else if (at_end) cnt_q <= '0;
        else             cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/ptim_wake.sv
// Sleep release logic. A request is armed once it has been seen for a full
// cycle; an armed, still-present request is released on the next fold.
// Assumes the requester holds its request until released.
module ptim_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic roll,
    output logic wake,
    output logic hold
);
    logic armed_q;

    // Release pulse and stall indication.
    always_comb begin
        wake = armed_q && sleep_req && roll;
        hold = sleep_req && !wake;
    end

    // Arm on a held request; disarm on release so the pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= sleep_req && !wake;
    end
endmodule

// File: rtl/ptim_top.sv
// Programmable period timer with sleep release.
// Holds the period register, instantiates decoder, counter and wake logic,
// and muxes the read port. Synchronous active-low reset.
module ptim_top
    import ptim_pkg::*;
#(
    parameter int W        = 16,
    parameter int ADDR_W   = 4,
    parameter int PRD_ADDR = 8,
    parameter int CNT_ADDR = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              sleep_req,
    output logic              wake_o,
    output logic              hold_o
);
    logic         prd_we;
    logic         cnt_we;
    ptim_rsel_e   rd_sel;
    logic [W-1:0] prd_q;
    logic [W-1:0] cnt_q;
    logic         roll;

    ptim_decode #(.ADDR_W(ADDR_W), .PRD_ADDR(PRD_ADDR), .CNT_ADDR(CNT_ADDR)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .prd_we  (prd_we),
        .cnt_we  (cnt_we),
        .rd_sel  (rd_sel)
    );

    // Period register.
    always_ff @(posedge clk) begin
        if (!rst_n)      prd_q <= '0;
        else if (prd_we) prd_q <= wr_data;
    end

    ptim_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .prd_q   (prd_q),
        .cnt_we  (cnt_we),
        .wr_data (wr_data),
        .cnt_q   (cnt_q),
        .roll    (roll)
    );

    ptim_wake u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .roll      (roll),
        .wake      (wake_o),
        .hold      (hold_o)
    );

    // Read port multiplexer.
    always_comb begin
        case (rd_sel)
            RSEL_PRD: rd_data = prd_q;
            RSEL_CNT: rd_data = cnt_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptim_chk.sv
// Checker for ptim_top, attached by bind. Observes ports plus the period,
// counter and fold signals. Assumes synchronous active-low reset.
module ptim_chk #(
    parameter int W        = 16,
    parameter int ADDR_W   = 4,
    parameter int PRD_ADDR = 8,
    parameter int CNT_ADDR = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic              sleep_req,
    input logic              wake_o,
    input logic [W-1:0]      prd_q,
    input logic [W-1:0]      cnt_q,
    input logic              roll
);
    logic c_we;
    logic p_we;
    // Independent decode of the write strobes.
    always_comb begin
        c_we = wr_en && (wr_addr == ADDR_W'(CNT_ADDR));
        p_we = wr_en && (wr_addr == ADDR_W'(PRD_ADDR));
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_we && !roll) |=> (cnt_q == W'($past(cnt_q) + W'(1))));

    assert_period_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_we && prd_q != '0 && cnt_q == W'(prd_q - W'(1))) |=> (cnt_q == '0));

    assert_top_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_we && cnt_q == {W{1'b1}}) |=> (cnt_q == '0));

    assert_prd_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        p_we |=> (prd_q == $past(wr_data)));

    assert_cnt_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |=> (cnt_q == $past(wr_data)));

    assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (sleep_req && !c_we && cnt_q != W'(cnt_q + W'(1)) && roll));

    assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    assert_late_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req) |=> !wake_o);
endmodule

bind ptim_top ptim_chk #(.W(W), .ADDR_W(ADDR_W), .PRD_ADDR(PRD_ADDR), .CNT_ADDR(CNT_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sleep_req (sleep_req),
    .wake_o    (wake_o),
    .prd_q     (prd_q),
    .cnt_q     (cnt_q),
    .roll      (roll)
);

// File: tb/ptim_top_tb_top.sv
// Bench for ptim_top: table of period/start/run/expected-count vectors, then
// directed tests for reset, port decode, write priority and sleep release.
module ptim_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sleep_req = 1'b0;
    logic        wake_o;
    logic        hold_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptim_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sleep_req(sleep_req), .wake_o(wake_o), .hold_o(hold_o)
    );

    // {period, start count, cycles to run, expected count}
    localparam logic [63:0] VEC [0:7] = '{
        64'h000A_0000_0007_0007,
        64'h000A_0000_000A_0000,
        64'h000A_0000_0017_0003,
        64'h0000_FFFE_0003_0001,
        64'h0005_0064_0003_0067,
        64'h0005_FFFD_0005_0002,
        64'h0001_0000_0004_0000,
        64'h0003_0002_0001_0000
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(4'd8, v); chk("R1 period", v, 16'h0);
        rd(4'd9, v); chk("R1 count", v, 16'h0);
        chk("R1 wake", {15'h0, wake_o}, 16'h0);

        // R2 R3 R5: vector table
        for (int i = 0; i < 8; i++) begin
            wr(4'd8, VEC[i][63:48]);
            wr(4'd9, VEC[i][47:32]);
            repeat (int'(VEC[i][31:16])) @(negedge clk);
            rd(4'd9, v);
            chk($sformatf("R2/R3/R5 vector %0d", i), v, VEC[i][15:0]);
        end

        // R4: unmapped write ignored, unmapped read is zero
        wr(4'd8, 16'd100);
        wr(4'd9, 16'd10);
        wr(4'd3, 16'h55AA);
        rd(4'd8, v); chk("R4 period kept", v, 16'd100);
        rd(4'd9, v); chk("R4 count kept", v, 16'd12);
        rd(4'd3, v); chk("R4 unmapped read", v, 16'h0);

        // R5: period write below count does not reset the counter
        wr(4'd8, 16'd0);
        wr(4'd9, 16'd50);
        wr(4'd8, 16'd20);
        rd(4'd9, v); chk("R5 no reset", v, 16'd52);
        rd(4'd8, v); chk("R5 period", v, 16'd20);

        // R6: counter write in fold cycle wins, no wake
        wr(4'd8, 16'd10);
        sleep_req = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'd9;
        @(negedge clk); wr_data = 16'd5;
        #1 chk("R6 no wake on write", {15'h0, wake_o}, 16'h0);
        @(negedge clk); wr_en = 1'b0;
        rd(4'd9, v); chk("R6 written value", v, 16'd5);
        sleep_req = 1'b0;

        // R7 R9: sleep released at fold, single pulse
        wr(4'd8, 16'd6);
        wr(4'd9, 16'd0);
        sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R7 no early wake", {15'h0, wake_o}, 16'h0);
        chk("R9 hold while waiting", {15'h0, hold_o}, 16'h1);
        repeat (2) @(negedge clk);
        rd(4'd9, v); chk("R7 at fold", v, 16'd5);
        chk("R7 wake pulse", {15'h0, wake_o}, 16'h1);
        chk("R9 hold drops", {15'h0, hold_o}, 16'h0);
        @(negedge clk);
        #1 chk("R7 one cycle", {15'h0, wake_o}, 16'h0);
        sleep_req = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd9, v); chk("R7 fold again", v, 16'd5);
        chk("R7 no request no wake", {15'h0, wake_o}, 16'h0);

        // R8: request rising in the fold cycle waits for the next fold
        wr(4'd8, 16'd4);
        wr(4'd9, 16'd0);
        repeat (3) @(negedge clk);
        sleep_req = 1'b1;
        #1 chk("R8 late request not woken", {15'h0, wake_o}, 16'h0);
        repeat (4) @(negedge clk);
        rd(4'd9, v); chk("R8 next fold", v, 16'd3);
        chk("R8 woken at next fold", {15'h0, wake_o}, 16'h1);
        sleep_req = 1'b0;

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'd9, v); chk("R1 count after reset", v, 16'h0);
        rd(4'd8, v); chk("R1 period after reset", v, 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule